// File: doc/BRIEF.md
# Four-Bit Ripple-Carry Arithmetic Logic Unit

This block is a purely combinational four-bit arithmetic logic unit made of identical one-bit slices. Every slice forms the bitwise AND, OR, XOR and NOR of its two operand bits. It also holds a one-bit full adder. A six-way selector in the slice picks which of these values becomes that bit of the result. A three-bit opcode drives all of the selectors together. A separate control bit chooses between addition and subtraction. Subtraction uses two's complement: operand B is inverted on its way into the adders, and the carry into bit 0 is forced high.

The carry passes through the four adders one at a time, from bit 0 up to bit 3. The top bit position produces a "set" value that says whether A is less than B as signed numbers. This value is wired only into the selector of bit 0, and the upper slices see a constant 0 on that input. This is how the set-less-than operation is built. A zero flag and a signed overflow flag are provided as outputs. The unit is meant to sit between operand registers and a result register in a simple datapath, and it has no state of its own.

Top module: `alu4_ripple`

## Requirements
- R1: The opcodes 000, 001, 010 and 011 give the bitwise AND, OR, XOR and NOR of A and B, in that order, whatever the value of add_sub.
- R2: With opcode 100 and add_sub = 0, result is (A + B) mod 16, and carry_out is the carry out of bit 3.
- R3: With opcode 100 and add_sub = 1, result is (A − B) mod 16, formed as A + ~B + 1. carry_out is 1 exactly when no borrow occurs, which is when A ≥ B as unsigned numbers.
- R4: With opcode 101, result is 0001 when A < B as signed four-bit numbers and 0000 otherwise. The answer is correct even when A − B overflows, and it does not depend on add_sub.
- R5: Opcodes 110 and 111 give a result of 0000.
- R6: zero is 1 exactly when all four result bits are 0, for every opcode.
- R7: With opcode 100, overflow is 1 exactly when the signed sum or difference falls outside the range −8 to 7. For every other opcode, overflow is 0.
- R8: The carry ripples through all four slices. For example, A = 1111 and B = 0001 added give result 0000, carry_out 1, overflow 0 and zero 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 4 | Operand A |
| b | input | 4 | Operand B |
| add_sub | input | 1 | 0 = add, 1 = subtract (applies to opcode 100) |
| op | input | 3 | Operation selector |
| result | output | 4 | Selected result |
| carry_out | output | 1 | Carry out of the top adder |
| overflow | output | 1 | Signed overflow for opcode 100, otherwise 0 |
| zero | output | 1 | High when result is 0000 |

## Verification
The unit holds no state, so any internal fault shows up at the ports as soon as the inputs settle. A broken link in the carry chain corrupts every sum bit above the break, and it also corrupts carry_out. A wrong set value appears only in bit 0 of a set-less-than result, and most clearly in the cases where the subtraction overflows. A selector fault appears only for the opcode it mis-decodes. For these reasons every opcode is run with both add_sub values across all 256 operand pairs.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  typedef enum logic [2:0] {
    OPC_AND   = 3'b000,
    OPC_OR    = 3'b001,
    OPC_XOR   = 3'b010,
    OPC_NOR   = 3'b011,
    OPC_ARITH = 3'b100,
    OPC_SLT   = 3'b101,
    OPC_RSV6  = 3'b110,
    OPC_RSV7  = 3'b111
  } alu_opc_e;

  // One-bit full adder: returns {carry, sum}
  function automatic logic [1:0] fa_bit(input logic x, input logic y, input logic cin);
    logic s;
    logic c;
    s = x ^ y ^ cin;
    c = (x & y) | (x & cin) | (y & cin);
    return {c, s};
  endfunction

  // Signed overflow of the top adder stage
  function automatic logic msb_ovf(input logic c_into, input logic c_out);
    return c_into ^ c_out;
  endfunction

endpackage

// File: rtl/alu4_slice.sv
module alu4_slice
  import alu4_pkg::*;
(
  input  logic     a_bit,
  input  logic     b_bit,
  input  logic     invert_b,
  input  logic     carry_in,
  input  logic     less_in,
  input  alu_opc_e opc,
  output logic     res_bit,
  output logic     sum_bit,
  output logic     carry_out
);

  logic       b_eff;
  logic [1:0] fa_out;
  logic       and_v, or_v, xor_v, nor_v;

  assign b_eff     = b_bit ^ invert_b;
  assign fa_out    = fa_bit(a_bit, b_eff, carry_in);
  assign sum_bit   = fa_out[0];
  assign carry_out = fa_out[1];

  assign and_v = a_bit & b_bit;
  assign or_v  = a_bit | b_bit;
  assign xor_v = a_bit ^ b_bit;
  assign nor_v = ~(a_bit | b_bit);

  always_comb begin
    unique case (opc)
      OPC_AND:   res_bit = and_v;
      OPC_OR:    res_bit = or_v;
      OPC_XOR:   res_bit = xor_v;
      OPC_NOR:   res_bit = nor_v;
      OPC_ARITH: res_bit = sum_bit;
      OPC_SLT:   res_bit = less_in;
      default:   res_bit = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu4_msb_logic.sv
module alu4_msb_logic
  import alu4_pkg::*;
(
  input  logic     c_into_msb,
  input  logic     c_out_msb,
  input  logic     msb_sum,
  input  alu_opc_e opc,
  output logic     set_bit,
  output logic     ovf_flag
);

  logic raw_ovf;

  assign raw_ovf  = msb_ovf(c_into_msb, c_out_msb);
  // sign of the true difference, corrected for overflow
  assign set_bit  = msb_sum ^ raw_ovf;
  assign ovf_flag = (opc == OPC_ARITH) ? raw_ovf : 1'b0;

endmodule

// File: rtl/alu4_zero_detect.sv
module alu4_zero_detect #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] res,
  output logic             is_zero
);

  assign is_zero = ~(|res);

endmodule

// File: rtl/alu4_ripple.sv
module alu4_ripple
  import alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             add_sub,
  input  logic [2:0]       op,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow,
  output logic             zero
);

  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH:0] ONE_EXT = (WIDTH+1)'(1);

  alu_opc_e         opc;
  logic             invert_b;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sums;
  logic [WIDTH-1:0] less_vec;
  logic             set_bit;

  assign opc      = alu_opc_e'(op);
  // set-less-than always subtracts, independent of add_sub
  assign invert_b = add_sub | (opc == OPC_SLT);
  assign carry[0] = invert_b;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      if (i == 0) begin : g_lsb
        assign less_vec[i] = set_bit;
      end else begin : g_upper
        assign less_vec[i] = 1'b0;
      end
      alu4_slice u_slice (
        .a_bit    (a[i]),
        .b_bit    (b[i]),
        .invert_b (invert_b),
        .carry_in (carry[i]),
        .less_in  (less_vec[i]),
        .opc      (opc),
        .res_bit  (result[i]),
        .sum_bit  (sums[i]),
        .carry_out(carry[i+1])
      );
    end
  endgenerate

  alu4_msb_logic u_msb (
    .c_into_msb(carry[MSB]),
    .c_out_msb (carry[WIDTH]),
    .msb_sum   (sums[MSB]),
    .opc       (opc),
    .set_bit   (set_bit),
    .ovf_flag  (overflow)
  );

  alu4_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .res    (result),
    .is_zero(zero)
  );

  assign carry_out = carry[WIDTH];

  always_comb begin
    // R2
    add_sum_chk: assert (!(opc == OPC_ARITH && !add_sub) ||
                         ({carry_out, result} == ({1'b0, a} + {1'b0, b})))
      else $error("ripple sum disagrees with A+B");
    // R3
    sub_diff_chk: assert (!(opc == OPC_ARITH && add_sub) ||
                          ({carry_out, result} == ({1'b0, a} + {1'b0, ~b} + ONE_EXT)))
      else $error("ripple difference disagrees with A-B");
    // R4
    slt_value_chk: assert (opc != OPC_SLT ||
                           (result == {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))}))
      else $error("set-less-than result wrong");
    // R5
    rsv_code_chk: assert (!(opc == OPC_RSV6 || opc == OPC_RSV7) || (result == '0))
      else $error("reserved opcode gave nonzero result");
    // R7
    no_overflow_chk: assert (opc == OPC_ARITH || !overflow)
      else $error("overflow raised outside arithmetic opcode");
  end

endmodule

// File: tb/sim_alu4_ripple.sv
module sim_alu4_ripple;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a = '0;
  logic [3:0] b = '0;
  logic       add_sub = 1'b0;
  logic [2:0] op = '0;
  logic [3:0] result;
  logic       carry_out, overflow, zero;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5ns clk = ~clk;

  alu4_ripple u0 (
    .a(a), .b(b), .add_sub(add_sub), .op(op),
    .result(result), .carry_out(carry_out), .overflow(overflow), .zero(zero)
  );

  // {op, add_sub, a, b, exp_result, exp_cout, exp_ovf, exp_zero}
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {3'b000, 1'b0, 4'b1100, 4'b1010, 4'b1000, 1'b0, 1'b0, 1'b0},
    {3'b100, 1'b0, 4'b1111, 4'b0001, 4'b0000, 1'b1, 1'b0, 1'b1},
    {3'b100, 1'b0, 4'b0111, 4'b0001, 4'b1000, 1'b0, 1'b1, 1'b0},
    {3'b100, 1'b1, 4'b1000, 4'b0001, 4'b0111, 1'b1, 1'b1, 1'b0},
    {3'b100, 1'b1, 4'b0011, 4'b0011, 4'b0000, 1'b1, 1'b0, 1'b1},
    {3'b101, 1'b0, 4'b0111, 4'b1000, 4'b0000, 1'b0, 1'b0, 1'b1},
    {3'b101, 1'b1, 4'b1000, 4'b0111, 4'b0001, 1'b0, 1'b0, 1'b0},
    {3'b011, 1'b0, 4'b0101, 4'b0011, 4'b1000, 1'b0, 1'b0, 1'b0},
    {3'b010, 1'b1, 4'b1111, 4'b0101, 4'b1010, 1'b0, 1'b0, 1'b0},
    {3'b110, 1'b0, 4'b1111, 4'b1111, 4'b0000, 1'b0, 1'b0, 1'b1}
  };

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'b000, 3'b001, 3'b010, 3'b011: return "R1";
      3'b100:                         return "R2/R3";
      3'b101:                         return "R4";
      default:                        return "R5";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d (op=%b as=%b a=%b b=%b)",
               req, what, act, exp, op, add_sub, a, b);
    end
  endtask

  // independent reference model, integer arithmetic
  task automatic model(input int o, input int s, input int x, input int y,
                       output int r, output int c, output int v);
    int sx, sy, full, sres;
    sx = (x > 7) ? x - 16 : x;
    sy = (y > 7) ? y - 16 : y;
    r = 0; c = 0; v = 0;
    case (o)
      0: r = x & y;
      1: r = x | y;
      2: r = x ^ y;
      3: r = 15 - (x | y);
      4: begin
        if (s == 0) begin
          full = x + y;
          sres = sx + sy;
        end else begin
          full = x + (15 - y) + 1;
          sres = sx - sy;
        end
        r = full % 16;
        c = full / 16;
        v = (sres < -8 || sres > 7) ? 1 : 0;
      end
      5: r = (sx < sy) ? 1 : 0;
      default: r = 0;
    endcase
  endtask

  task automatic apply(input logic [2:0] o, input logic s, input logic [3:0] x, input logic [3:0] y);
    @(negedge clk);
    op = o; add_sub = s; a = x; b = y;
    #1ns;
  endtask

  initial begin : watchdog
    #(5ns * 200000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : stim
    int r, c, v;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: inputs idle at zero, AND of zeros -> result 0, zero flag high (R6)
    apply(3'b000, 1'b0, 4'b0000, 4'b0000);
    check("R6", "idle result", int'(result), 0);
    check("R6", "idle zero", int'(zero), 1);
    check("R7", "idle overflow", int'(overflow), 0);

    // directed vector table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][18:16], VEC[i][15], VEC[i][14:11], VEC[i][10:7]);
      check(req_of(VEC[i][18:16]), "vector result", int'(result), int'(VEC[i][6:3]));
      check("R6", "vector zero", int'(zero), int'(VEC[i][0]));
      check("R7", "vector overflow", int'(overflow), int'(VEC[i][1]));
      if (VEC[i][18:16] == 3'b100)
        check("R8", "vector carry", int'(carry_out), int'(VEC[i][2]));
    end

    // exhaustive sweep: every opcode, both add_sub values, all operand pairs
    for (int o = 0; o < 8; o++) begin
      for (int s = 0; s < 2; s++) begin
        for (int x = 0; x < 16; x++) begin
          for (int y = 0; y < 16; y++) begin
            apply(3'(o), 1'(s), 4'(x), 4'(y));
            model(o, s, x, y, r, c, v);
            check(req_of(3'(o)), "sweep result", int'(result), r);
            check("R6", "sweep zero", int'(zero), (r == 0) ? 1 : 0);
            check("R7", "sweep overflow", int'(overflow), v);
            if (o == 4)
              check((s == 0) ? "R2" : "R3", "sweep carry", int'(carry_out), c);
          end
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule